// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control unit of a single-cycle execution core. It is purely combinational. It looks at the 6-bit primary opcode and the 6-bit function field of the instruction that is being executed. From them it produces the strobes that steer the data path: register write, second ALU operand, add/subtract, ALU function class, logic function, data-memory read and write, destination-register choice and next-address choice.

The decoder works in two levels. The first level turns the two fields into one flag per supported instruction; there are 22 of them. The second level builds three class terms from those flags: arithmetic, logic and immediate. It then forms every strobe by OR-ing class terms and single instruction flags. The control strobes leave the generator as one packed struct, and the top module splits that struct into plain ports. An opcode or function value that is not in the supported set produces the all-zero strobe word, so it behaves as a no-operation that falls through to the next sequential address.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: The supported encodings are the following. Function values apply with opcode 0: add 32, sub 34, slt 42, and 36, or 37, xor 38, nor 39, jr 8, syscall 12. The remaining instructions are opcodes: bltz 1, j 2, jal 3, beq 4, bne 5, addi 8, slti 10, andi 12, ori 13, xori 14, lui 15, lw 35, sw 43. Exactly 13 nonzero opcodes and 9 function values with opcode 0 are recognised.
- R2: `regWrite` is 1 for lui, for the arithmetic class (add, sub, slt, addi, slti), for the logic class (and, or, xor, nor, andi, ori, xori), for lw and for jal. It is 0 for every other input.
- R3: `aluSrcImm` is 1 for the immediate class (lui, addi, slti, andi, ori, xori), for lw and for sw. It is 0 otherwise.
- R4: `subSel` is 1 only for sub, slt and slti.
- R5: `fnClass` is 2'b00 for lui and for every instruction that does not use the ALU. It is 2'b01 for slt and slti, 2'b10 for add, sub, addi, lw and sw, and 2'b11 for the logic class.
- R6: `logicFn` is 2'b00 for and/andi, 2'b01 for or/ori, 2'b10 for xor/xori and 2'b11 for nor. It is 2'b00 for everything outside the logic class.
- R7: `dataRead` is 1 only for lw and `dataWrite` is 1 only for sw. The two are never 1 together.
- R8: `dstSel` is 2'b01 (rd) for the seven register-format ALU instructions, 2'b10 (link register 31) for jal, and 2'b00 (rt) for the immediate-format ALU instructions and lw. It is 2'b00 whenever `regWrite` is 0.
- R9: `nextSel` is 0 for sequential flow, 1 for j and jal, 2 for jr, 3 for syscall, 4 for bltz, 5 for beq and 6 for bne. Branches, j, jr and syscall write neither a register nor memory.
- R10: Any opcode or function value outside R1 drives every output to zero.
- R11: When the opcode is nonzero, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opField | input | 6 | Primary opcode field of the instruction |
| fnField | input | 6 | Function field (used when opField is 0) |
| regWrite | output | 1 | Register file write enable |
| aluSrcImm | output | 1 | Second ALU operand is the immediate |
| subSel | output | 1 | Adder performs subtraction |
| fnClass | output | 2 | ALU function class |
| logicFn | output | 2 | Logic unit function |
| dataRead | output | 1 | Data memory read enable |
| dataWrite | output | 1 | Data memory write enable |
| dstSel | output | 2 | Destination register choice |
| nextSel | output | 3 | Next-address source choice |

## Verification
The bench builds the block with the package defaults of 6-bit opcode and function fields. At that width every value of each field can be swept exhaustively. The bench walks every supported instruction against a fixed expected-strobe table. It then counts how many of the 64 opcodes and how many of the 64 function values give a nonzero strobe word, which exposes a spurious or a missing decode. Finally it sweeps all function values under a nonzero opcode to show that the function field is ignored there.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int FNC_W = 2;
  localparam int LGC_W = 2;
  localparam int DST_W = 2;
  localparam int NXT_W = 3;

  localparam logic [OP_W-1:0] OP_RTYPE = OP_W'(0);
  localparam logic [OP_W-1:0] OP_BLTZ  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_J     = OP_W'(2);
  localparam logic [OP_W-1:0] OP_JAL   = OP_W'(3);
  localparam logic [OP_W-1:0] OP_BEQ   = OP_W'(4);
  localparam logic [OP_W-1:0] OP_BNE   = OP_W'(5);
  localparam logic [OP_W-1:0] OP_ADDI  = OP_W'(8);
  localparam logic [OP_W-1:0] OP_SLTI  = OP_W'(10);
  localparam logic [OP_W-1:0] OP_ANDI  = OP_W'(12);
  localparam logic [OP_W-1:0] OP_ORI   = OP_W'(13);
  localparam logic [OP_W-1:0] OP_XORI  = OP_W'(14);
  localparam logic [OP_W-1:0] OP_LUI   = OP_W'(15);
  localparam logic [OP_W-1:0] OP_LW    = OP_W'(35);
  localparam logic [OP_W-1:0] OP_SW    = OP_W'(43);

  localparam logic [FN_W-1:0] FN_JR    = FN_W'(8);
  localparam logic [FN_W-1:0] FN_SYS   = FN_W'(12);
  localparam logic [FN_W-1:0] FN_ADD   = FN_W'(32);
  localparam logic [FN_W-1:0] FN_SUB   = FN_W'(34);
  localparam logic [FN_W-1:0] FN_AND   = FN_W'(36);
  localparam logic [FN_W-1:0] FN_OR    = FN_W'(37);
  localparam logic [FN_W-1:0] FN_XOR   = FN_W'(38);
  localparam logic [FN_W-1:0] FN_NOR   = FN_W'(39);
  localparam logic [FN_W-1:0] FN_SLT   = FN_W'(42);

  localparam logic [FNC_W-1:0] FC_UPPER = 2'b00;
  localparam logic [FNC_W-1:0] FC_LESS  = 2'b01;
  localparam logic [FNC_W-1:0] FC_ARITH = 2'b10;
  localparam logic [FNC_W-1:0] FC_LOGIC = 2'b11;

  localparam logic [DST_W-1:0] DST_RT   = 2'b00;
  localparam logic [DST_W-1:0] DST_RD   = 2'b01;
  localparam logic [DST_W-1:0] DST_LINK = 2'b10;

  localparam logic [NXT_W-1:0] NX_SEQ  = 3'd0;
  localparam logic [NXT_W-1:0] NX_JTA  = 3'd1;
  localparam logic [NXT_W-1:0] NX_REG  = 3'd2;
  localparam logic [NXT_W-1:0] NX_SYS  = 3'd3;
  localparam logic [NXT_W-1:0] NX_BLTZ = 3'd4;
  localparam logic [NXT_W-1:0] NX_BEQ  = 3'd5;
  localparam logic [NXT_W-1:0] NX_BNE  = 3'd6;

  typedef struct packed {
    logic isAdd;  logic isSub;  logic isSlt;
    logic isAnd;  logic isOr;   logic isXor;  logic isNor;
    logic isJr;   logic isSys;
    logic isLui;  logic isAddi; logic isSlti;
    logic isAndi; logic isOri;  logic isXori;
    logic isLw;   logic isSw;
    logic isBltz; logic isBeq;  logic isBne;
    logic isJ;    logic isJal;
  } instrHit_t;

  typedef struct packed {
    logic              regWrite;
    logic              aluSrcImm;
    logic              subSel;
    logic [FNC_W-1:0]  fnClass;
    logic [LGC_W-1:0]  logicFn;
    logic              dataRead;
    logic              dataWrite;
    logic [DST_W-1:0]  dstSel;
    logic [NXT_W-1:0]  nextSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/ictl_class_decode.sv
module ictl_class_decode
  import ictl_pkg::*;
(
  input  logic [OP_W-1:0] opField,
  input  logic [FN_W-1:0] fnField,
  output instrHit_t       hit
);
  instrHit_t opHit;
  instrHit_t fnHit;

  always_comb begin
    opHit = '0;
    case (opField)
      OP_BLTZ: opHit.isBltz = 1'b1;
      OP_J:    opHit.isJ    = 1'b1;
      OP_JAL:  opHit.isJal  = 1'b1;
      OP_BEQ:  opHit.isBeq  = 1'b1;
      OP_BNE:  opHit.isBne  = 1'b1;
      OP_ADDI: opHit.isAddi = 1'b1;
      OP_SLTI: opHit.isSlti = 1'b1;
      OP_ANDI: opHit.isAndi = 1'b1;
      OP_ORI:  opHit.isOri  = 1'b1;
      OP_XORI: opHit.isXori = 1'b1;
      OP_LUI:  opHit.isLui  = 1'b1;
      OP_LW:   opHit.isLw   = 1'b1;
      OP_SW:   opHit.isSw   = 1'b1;
      default: opHit = '0;
    endcase
  end

  always_comb begin
    fnHit = '0;
    if (opField == OP_RTYPE) begin
      case (fnField)
        FN_ADD:  fnHit.isAdd = 1'b1;
        FN_SUB:  fnHit.isSub = 1'b1;
        FN_SLT:  fnHit.isSlt = 1'b1;
        FN_AND:  fnHit.isAnd = 1'b1;
        FN_OR:   fnHit.isOr  = 1'b1;
        FN_XOR:  fnHit.isXor = 1'b1;
        FN_NOR:  fnHit.isNor = 1'b1;
        FN_JR:   fnHit.isJr  = 1'b1;
        FN_SYS:  fnHit.isSys = 1'b1;
        default: fnHit = '0;
      endcase
    end
  end

  assign hit = opHit | fnHit;
endmodule

// File: rtl/ictl_strobe_gen.sv
module ictl_strobe_gen
  import ictl_pkg::*;
(
  input  instrHit_t    hit,
  output ctrlStrobes_t strobes
);
  logic arithClass;
  logic logicClass;
  logic immClass;
  logic regAluClass;
  logic addSubClass;

  assign arithClass  = hit.isAdd | hit.isSub | hit.isSlt | hit.isAddi | hit.isSlti;
  assign logicClass  = hit.isAnd | hit.isOr | hit.isXor | hit.isNor
                     | hit.isAndi | hit.isOri | hit.isXori;
  assign immClass    = hit.isLui | hit.isAddi | hit.isSlti
                     | hit.isAndi | hit.isOri | hit.isXori;
  assign regAluClass = hit.isAdd | hit.isSub | hit.isSlt
                     | hit.isAnd | hit.isOr | hit.isXor | hit.isNor;
  assign addSubClass = hit.isAdd | hit.isSub | hit.isAddi;

  always_comb begin
    strobes = '0;
    strobes.regWrite   = hit.isLui | arithClass | logicClass | hit.isLw | hit.isJal;
    strobes.aluSrcImm  = immClass | hit.isLw | hit.isSw;
    strobes.subSel     = hit.isSub | hit.isSlt | hit.isSlti;
    strobes.fnClass[1] = addSubClass | logicClass | hit.isLw | hit.isSw;
    strobes.fnClass[0] = logicClass | hit.isSlt | hit.isSlti;
    strobes.logicFn[1] = hit.isXor | hit.isXori | hit.isNor;
    strobes.logicFn[0] = hit.isOr | hit.isOri | hit.isNor;
    strobes.dataRead   = hit.isLw;
    strobes.dataWrite  = hit.isSw;

    if (regAluClass)     strobes.dstSel = DST_RD;
    else if (hit.isJal)  strobes.dstSel = DST_LINK;
    else                 strobes.dstSel = DST_RT;

    if (hit.isJ | hit.isJal) strobes.nextSel = NX_JTA;
    else if (hit.isJr)       strobes.nextSel = NX_REG;
    else if (hit.isSys)      strobes.nextSel = NX_SYS;
    else if (hit.isBltz)     strobes.nextSel = NX_BLTZ;
    else if (hit.isBeq)      strobes.nextSel = NX_BEQ;
    else if (hit.isBne)      strobes.nextSel = NX_BNE;
    else                     strobes.nextSel = NX_SEQ;
  end
endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
  import ictl_pkg::*;
(
  input  logic [OP_W-1:0]  opField,
  input  logic [FN_W-1:0]  fnField,
  output logic             regWrite,
  output logic             aluSrcImm,
  output logic             subSel,
  output logic [FNC_W-1:0] fnClass,
  output logic [LGC_W-1:0] logicFn,
  output logic             dataRead,
  output logic             dataWrite,
  output logic [DST_W-1:0] dstSel,
  output logic [NXT_W-1:0] nextSel
);
  instrHit_t    hit;
  ctrlStrobes_t strobes;

  ictl_class_decode u_decode (
    .opField (opField),
    .fnField (fnField),
    .hit     (hit)
  );

  ictl_strobe_gen u_strobe (
    .hit     (hit),
    .strobes (strobes)
  );

  assign regWrite  = strobes.regWrite;
  assign aluSrcImm = strobes.aluSrcImm;
  assign subSel    = strobes.subSel;
  assign fnClass   = strobes.fnClass;
  assign logicFn   = strobes.logicFn;
  assign dataRead  = strobes.dataRead;
  assign dataWrite = strobes.dataWrite;
  assign dstSel    = strobes.dstSel;
  assign nextSel   = strobes.nextSel;
endmodule

// File: rtl/instr_ctrl_decoder_chk.sv
module instr_ctrl_decoder_chk
  import ictl_pkg::*;
(
  input logic [OP_W-1:0]  opField,
  input logic [FN_W-1:0]  fnField,
  input logic             regWrite,
  input logic             aluSrcImm,
  input logic             subSel,
  input logic [FNC_W-1:0] fnClass,
  input logic [LGC_W-1:0] logicFn,
  input logic             dataRead,
  input logic             dataWrite,
  input logic [DST_W-1:0] dstSel,
  input logic [NXT_W-1:0] nextSel
);
  always_comb begin
    if (!$isunknown({opField, fnField})) begin
      p_mem_excl_r7:   assert (!(dataRead && dataWrite));
      p_load_wr_r7:    assert (!dataRead || (regWrite && aluSrcImm));
      p_store_r3:      assert (!dataWrite || (aluSrcImm && !regWrite));
      p_dst_idle_r8:   assert (regWrite || dstSel == DST_RT);
      p_link_r8:       assert (dstSel != DST_LINK || nextSel == NX_JTA);
      p_flow_nowr_r9:  assert (nextSel == NX_SEQ || (!dataRead && !dataWrite));
      p_flow_noreg_r9: assert (nextSel == NX_SEQ || nextSel == NX_JTA || !regWrite);
      p_nx_range_r9:   assert (nextSel <= NX_BNE);
      p_lfn_class_r6:  assert (logicFn == 2'b00 || fnClass == FC_LOGIC);
      p_sub_class_r4:  assert (!subSel || fnClass == FC_ARITH || fnClass == FC_LESS);
      p_less_sub_r4:   assert (fnClass != FC_LESS || subSel);
      p_upper_imm_r5:  assert (!(fnClass == FC_UPPER && regWrite && dstSel == DST_RT
                                 && !dataRead) || aluSrcImm);
      p_fn_ignored_r11: assert (opField == OP_RTYPE || !(dstSel == DST_RD));
    end
  end
endmodule

bind instr_ctrl_decoder instr_ctrl_decoder_chk u_chk (
  .opField   (opField),
  .fnField   (fnField),
  .regWrite  (regWrite),
  .aluSrcImm (aluSrcImm),
  .subSel    (subSel),
  .fnClass   (fnClass),
  .logicFn   (logicFn),
  .dataRead  (dataRead),
  .dataWrite (dataWrite),
  .dstSel    (dstSel),
  .nextSel   (nextSel)
);

// File: tb/tb_instr_ctrl_decoder.sv
module tb_instr_ctrl_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [5:0] opField;
  logic [5:0] fnField;
  logic       regWrite, aluSrcImm, subSel, dataRead, dataWrite;
  logic [1:0] fnClass, logicFn, dstSel;
  logic [2:0] nextSel;

  instr_ctrl_decoder dut (
    .opField(opField), .fnField(fnField),
    .regWrite(regWrite), .aluSrcImm(aluSrcImm), .subSel(subSel),
    .fnClass(fnClass), .logicFn(logicFn), .dataRead(dataRead),
    .dataWrite(dataWrite), .dstSel(dstSel), .nextSel(nextSel)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // {op, fn, rw, imm, sub, fnClass, logicFn, rd, wr, dst, next}
  localparam int NV = 27;
  localparam logic [25:0] VEC [0:NV-1] = '{
    {6'd0,  6'd32, 14'b1_0_0_10_00_0_0_01_000},  // add
    {6'd0,  6'd34, 14'b1_0_1_10_00_0_0_01_000},  // sub
    {6'd0,  6'd42, 14'b1_0_1_01_00_0_0_01_000},  // slt
    {6'd0,  6'd36, 14'b1_0_0_11_00_0_0_01_000},  // and
    {6'd0,  6'd37, 14'b1_0_0_11_01_0_0_01_000},  // or
    {6'd0,  6'd38, 14'b1_0_0_11_10_0_0_01_000},  // xor
    {6'd0,  6'd39, 14'b1_0_0_11_11_0_0_01_000},  // nor
    {6'd15, 6'd0,  14'b1_1_0_00_00_0_0_00_000},  // lui
    {6'd8,  6'd0,  14'b1_1_0_10_00_0_0_00_000},  // addi
    {6'd10, 6'd0,  14'b1_1_1_01_00_0_0_00_000},  // slti
    {6'd12, 6'd0,  14'b1_1_0_11_00_0_0_00_000},  // andi
    {6'd13, 6'd0,  14'b1_1_0_11_01_0_0_00_000},  // ori
    {6'd14, 6'd0,  14'b1_1_0_11_10_0_0_00_000},  // xori
    {6'd35, 6'd0,  14'b1_1_0_10_00_1_0_00_000},  // lw
    {6'd43, 6'd0,  14'b0_1_0_10_00_0_1_00_000},  // sw
    {6'd1,  6'd0,  14'b0_0_0_00_00_0_0_00_100},  // bltz
    {6'd4,  6'd0,  14'b0_0_0_00_00_0_0_00_101},  // beq
    {6'd5,  6'd0,  14'b0_0_0_00_00_0_0_00_110},  // bne
    {6'd2,  6'd0,  14'b0_0_0_00_00_0_0_00_001},  // j
    {6'd0,  6'd8,  14'b0_0_0_00_00_0_0_00_010},  // jr
    {6'd3,  6'd0,  14'b1_0_0_00_00_0_0_10_001},  // jal
    {6'd0,  6'd12, 14'b0_0_0_00_00_0_0_00_011},  // syscall
    {6'd63, 6'd0,  14'b0_0_0_00_00_0_0_00_000},  // unlisted opcode
    {6'd9,  6'd32, 14'b0_0_0_00_00_0_0_00_000},  // unlisted opcode, add funct
    {6'd0,  6'd33, 14'b0_0_0_00_00_0_0_00_000},  // unlisted funct
    {6'd8,  6'd42, 14'b1_1_0_10_00_0_0_00_000},  // addi with slt funct
    {6'd1,  6'd34, 14'b0_0_0_00_00_0_0_00_100}   // bltz with sub funct
  };

  function automatic logic [13:0] outWord();
    return {regWrite, aluSrcImm, subSel, fnClass, logicFn,
            dataRead, dataWrite, dstSel, nextSel};
  endfunction

  task automatic checkVal(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s op=%0d fn=%0d actual=%0d expected=%0d",
               tag, opField, fnField, actual, expected);
    end
  endtask

  task automatic applyIn(input logic [5:0] op, input logic [5:0] fn);
    @(negedge clk);
    opField = op;
    fnField = fn;
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      finishRun();
    end
  end

  initial begin
    opField = '0;
    fnField = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // Reset state: op 0 / fn 0 is unlisted, all strobes zero (R10)
    applyIn(6'd0, 6'd0);
    checkVal("R10 reset-state word", int'(outWord()), 0);

    // Table walk, each field named by its requirement
    for (int i = 0; i < NV; i++) begin
      logic [13:0] e;
      e = VEC[i][13:0];
      applyIn(VEC[i][25:20], VEC[i][19:14]);
      checkVal("R2 regWrite",  int'(regWrite),  int'(e[13]));
      checkVal("R3 aluSrcImm", int'(aluSrcImm), int'(e[12]));
      checkVal("R4 subSel",    int'(subSel),    int'(e[11]));
      checkVal("R5 fnClass",   int'(fnClass),   int'(e[10:9]));
      checkVal("R6 logicFn",   int'(logicFn),   int'(e[8:7]));
      checkVal("R7 dataRead",  int'(dataRead),  int'(e[6]));
      checkVal("R7 dataWrite", int'(dataWrite), int'(e[5]));
      checkVal("R8 dstSel",    int'(dstSel),    int'(e[4:3]));
      checkVal("R9 nextSel",   int'(nextSel),   int'(e[2:0]));
      if (i >= 22 && i <= 24)
        checkVal("R10 unlisted word", int'(outWord()), int'(e));
      if (i >= 25)
        checkVal("R11 funct ignored word", int'(outWord()), int'(e));
    end

    // R1: count recognised opcodes (fn 0) and recognised functs (op 0)
    begin
      int nOp = 0;
      int nFn = 0;
      for (int k = 0; k < 64; k++) begin
        applyIn(6'(k), 6'd0);
        if (outWord() != 14'd0) nOp++;
      end
      for (int k = 0; k < 64; k++) begin
        applyIn(6'd0, 6'(k));
        if (outWord() != 14'd0) nFn++;
      end
      checkVal("R1 recognised opcodes", nOp, 13);
      checkVal("R1 recognised functs", nFn, 9);
    end

    // R11: full funct sweep under addi and under sw
    for (int k = 0; k < 64; k++) begin
      applyIn(6'd8, 6'(k));
      checkVal("R11 addi funct sweep", int'(outWord()), int'(14'b1_1_0_10_00_0_0_00_000));
      applyIn(6'd43, 6'(k));
      checkVal("R11 sw funct sweep", int'(outWord()), int'(14'b0_1_0_10_00_0_1_00_000));
    end

    finishRun();
  end
endmodule